// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block is a single-port, clock-synchronous memory with a small internal array: 64 words by default, each 36 bits wide in four 9-bit byte lanes. Every control input is registered on the rising edge of the clock. These inputs are the address, three chip selects, write enable, per-lane write selects, advance/load and an active-low clock enable. Each edge either starts an access at a new address or moves a 2-bit burst counter to the next word of a four-word group. A static order input sets the counter sequence to linear or interleaved.

Reads and writes run on one pipeline, so a read can follow a write with no idle cycle. Read data for an access comes out in the window after the next enabled edge. Write data for a write access is expected on the bus in that same window and is stored at the edge that follows. Because a write's data never arrives in the same window as a read's output, the bus never has to turn around. The external bidirectional bus is split into three ports here: separate input data, output data and a drive-enable. The drive-enable obeys the output-enable pin only in windows that carry read data.

Top module: `sram_burst_core`

## Requirements
- R1: While `rst_n` is low, `bus_drive` is 0 and `rdata` is all zeros.
- R2: On an edge where `clk_en_n` is 1, every synchronous input is ignored. No state changes, no array write happens, and `rdata` and the drive window hold their previous values.
- R3: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on an edge with `adv_ld`=0. Any other chip-select combination on such an edge deselects the block, and that edge starts no access.
- R4: `adv_ld`=0 on a selected, enabled edge loads `addr` as a new access. A read is selected by `we_n`=1. The word at that address appears on `rdata` after the next enabled edge.
- R5: `adv_ld`=1 on an enabled edge continues the current burst with the same read or write type as its load. Bits [5:2] of the address stay fixed. If the block is deselected, `adv_ld`=1 starts nothing.
- R6: With `order_ilv`=0 (linear order), beat k of a burst that starts at low bits s uses low bits (s+k) mod 4.
- R7: With `order_ilv`=1 (interleaved order), beat k of a burst that starts at low bits s uses low bits s XOR k.
- R8: A write access is selected by `we_n`=0. Its data is taken from `wdata` on the second enabled edge after its address. Lane i, bits [9i+8:9i], is written only if `lane_we_n[i]` was 0 on the address edge.
- R9: A read issued on the edge right after a write to the same address returns the merged word: the newly written lanes plus the old contents of the other lanes.
- R10: `bus_drive` is 1 only in a read-data window while `oe_n` is 0. It stays 0 in write-data windows and in the first window after a deselect.
- R11: Reset empties the pipeline. No access issued before reset produces read data or an array write after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command, active low |
| lane_we_n | input | 4 | Per-lane write selects, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write data (input half of the bus) |
| oe_n | input | 1 | Output enable, active low |
| rdata | output | 36 | Read data (output half of the bus) |
| bus_drive | output | 1 | Bus drive enable |

## Verification
An access loaded at edge k returns read data, or consumes write data, in the window after edge k+1. Every edge where `clk_en_n` is high pushes that window back one cycle. The bench drives inputs on the falling edge and advances a behavioural model at each rising edge, using the same inputs the design sampled. It compares `bus_drive`, and `rdata` whenever the model holds valid read data, at the next falling edge. Each result is therefore checked in the exact window it is due, whatever the pattern of stalls, and a result that comes one cycle early or late fails.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  // Low two bits of burst beat `cnt` for a burst starting at `start`.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       linear);
    beat_low = linear ? (start + cnt) : (start ^ cnt);
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] next_addr
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [1:0]        cnt_inc;

  assign cnt_inc   = cnt_q + 2'd1;
  assign next_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_inc, linear)};

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = load_addr;
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d  = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_lanes.sv
module sram_lanes #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/sram_burst_core.sv
module sram_burst_core
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    adv_ld,
  input  logic                    order_ilv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    bus_drive
);

  localparam int DATA_W = LANES * LANE_W;

  logic en, selected, load_sel;
  assign en       = !clk_en_n;
  assign selected = !ce1_n && ce2 && !ce3_n;
  assign load_sel = en && !adv_ld && selected;

  // burst tracking
  logic burst_act_q, burst_act_d, burst_wr_q, burst_wr_d;
  // address stage
  logic              s1_vld_q, s1_vld_d, s1_wr_q, s1_wr_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d;
  logic [LANES-1:0]  s1_be_q, s1_be_d;
  // data stage
  logic              wr_pend_q, wr_pend_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [LANES-1:0]  wr_be_q, wr_be_d;
  logic              rd_vld_q, rd_vld_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [ADDR_W-1:0] burst_next;
  logic [DATA_W-1:0] arr_rd, merged;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_sel),
    .step      (en && adv_ld && burst_act_q),
    .linear    (!order_ilv),
    .load_addr (addr),
    .next_addr (burst_next)
  );

  sram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (en && wr_pend_q),
    .waddr (wr_addr_q),
    .wbe   (wr_be_q),
    .wdata (wdata),
    .raddr (s1_addr_q),
    .rdata (arr_rd)
  );

  // Forward lanes of a write retiring on the same edge as a read of its address.
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] =
      (wr_pend_q && (wr_addr_q == s1_addr_q) && wr_be_q[g])
        ? wdata[g*LANE_W +: LANE_W] : arr_rd[g*LANE_W +: LANE_W];
  end

  always_comb begin
    burst_act_d = burst_act_q;
    burst_wr_d  = burst_wr_q;
    s1_vld_d    = s1_vld_q;
    s1_wr_d     = s1_wr_q;
    s1_addr_d   = s1_addr_q;
    s1_be_d     = s1_be_q;
    wr_pend_d   = wr_pend_q;
    wr_addr_d   = wr_addr_q;
    wr_be_d     = wr_be_q;
    rd_vld_d    = rd_vld_q;
    rdata_d     = rdata_q;
    if (en) begin
      // data stage takes over the address stage
      wr_pend_d = s1_vld_q && s1_wr_q;
      wr_addr_d = s1_addr_q;
      wr_be_d   = s1_be_q;
      rd_vld_d  = s1_vld_q && !s1_wr_q;
      if (s1_vld_q && !s1_wr_q) rdata_d = merged;
      // address stage takes the new command
      s1_be_d = ~lane_we_n;
      if (!adv_ld) begin
        burst_act_d = selected;
        burst_wr_d  = !we_n;
        s1_vld_d    = selected;
        s1_wr_d     = !we_n;
        s1_addr_d   = addr;
      end else begin
        s1_vld_d  = burst_act_q;
        s1_wr_d   = burst_wr_q;
        s1_addr_d = burst_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act_q <= 1'b0;
      burst_wr_q  <= 1'b0;
      s1_vld_q    <= 1'b0;
      s1_wr_q     <= 1'b0;
      s1_addr_q   <= '0;
      s1_be_q     <= '0;
      wr_pend_q   <= 1'b0;
      wr_addr_q   <= '0;
      wr_be_q     <= '0;
      rd_vld_q    <= 1'b0;
      rdata_q     <= '0;
    end else begin
      burst_act_q <= burst_act_d;
      burst_wr_q  <= burst_wr_d;
      s1_vld_q    <= s1_vld_d;
      s1_wr_q     <= s1_wr_d;
      s1_addr_q   <= s1_addr_d;
      s1_be_q     <= s1_be_d;
      wr_pend_q   <= wr_pend_d;
      wr_addr_q   <= wr_addr_d;
      wr_be_q     <= wr_be_d;
      rd_vld_q    <= rd_vld_d;
      rdata_q     <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign bus_drive = rd_vld_q && !oe_n;

endmodule

// File: rtl/sram_burst_core_chk.sv
module sram_burst_core_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              adv_ld,
  input logic              bus_drive,
  input logic [DATA_W-1:0] rdata,
  input logic              s1_vld_q,
  input logic [ADDR_W-1:0] s1_addr_q,
  input logic              wr_pend_q
);

  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(rdata));

  assert_desel_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |=> !s1_vld_q);

  assert_burst_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && s1_vld_q) |=>
      (s1_addr_q[ADDR_W-1:2] == $past(s1_addr_q[ADDR_W-1:2])));

  assert_no_drive_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> !wr_pend_q);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |-> !bus_drive);

endmodule

bind sram_burst_core sram_burst_core_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en_n  (clk_en_n),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .ce3_n     (ce3_n),
  .adv_ld    (adv_ld),
  .bus_drive (bus_drive),
  .rdata     (rdata),
  .s1_vld_q  (s1_vld_q),
  .s1_addr_q (s1_addr_q),
  .wr_pend_q (wr_pend_q)
);

// File: tb/sram_burst_core_test.sv
module sram_burst_core_test;

  logic        clk = 1'b0;
  logic        rst_n, clk_en_n, ce1_n, ce2, ce3_n, we_n, adv_ld, order_ilv, oe_n;
  logic [3:0]  lane_we_n;
  logic [5:0]  addr;
  logic [35:0] wdata;
  logic [35:0] rdata;
  logic        bus_drive;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sram_burst_core uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .we_n(we_n), .lane_we_n(lane_we_n), .adv_ld(adv_ld),
    .order_ilv(order_ilv), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .bus_drive(bus_drive)
  );

  // behavioural reference
  logic [35:0] ref_mem [64];
  bit          m_act, m_wr;
  logic [5:0]  m_base;
  int          m_beat;
  bit          m_a_v, m_a_w;
  logic [5:0]  m_a_addr;
  logic [3:0]  m_a_be;
  bit          m_w_v;
  logic [5:0]  m_w_addr;
  logic [3:0]  m_w_be;
  bit          m_out_v;
  logic [35:0] m_out_d;

  task automatic model_reset();
    m_act = 0; m_wr = 0; m_base = 0; m_beat = 0;
    m_a_v = 0; m_a_w = 0; m_a_addr = 0; m_a_be = 0;
    m_w_v = 0; m_w_addr = 0; m_w_be = 0;
    m_out_v = 0; m_out_d = '0;
  endtask

  task automatic model_edge();
    int low;
    if (!rst_n) begin
      model_reset();
    end else if (!clk_en_n) begin
      if (m_w_v)
        for (int i = 0; i < 4; i++)
          if (m_w_be[i]) ref_mem[m_w_addr][i*9 +: 9] = wdata[i*9 +: 9];
      m_out_v = m_a_v && !m_a_w;
      if (m_out_v) m_out_d = ref_mem[m_a_addr];
      m_w_v = m_a_v && m_a_w; m_w_addr = m_a_addr; m_w_be = m_a_be;
      m_a_be = ~lane_we_n;
      if (!adv_ld) begin
        m_act = !ce1_n && ce2 && !ce3_n;
        m_wr = !we_n; m_base = addr; m_beat = 0;
        m_a_v = m_act; m_a_w = m_wr; m_a_addr = addr;
      end else if (m_act) begin
        m_beat = (m_beat + 1) % 4;
        low = order_ilv ? (int'(m_base[1:0]) ^ m_beat) : ((int'(m_base[1:0]) + m_beat) % 4);
        m_a_v = 1; m_a_w = m_wr; m_a_addr = {m_base[5:2], 2'(low)};
      end else begin
        m_a_v = 0;
      end
    end
  endtask

  task automatic tick(input string tag);
    wdata = {4'($urandom), 32'($urandom)};
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (bus_drive !== (m_out_v && !oe_n)) begin
      fails++;
      $display("FAIL %s bus_drive actual %0b expected %0b", tag, bus_drive, m_out_v && !oe_n);
    end
    if (m_out_v) begin
      checks++;
      if (rdata !== m_out_d) begin
        fails++;
        $display("FAIL %s rdata actual %h expected %h", tag, rdata, m_out_d);
      end
    end
  endtask

  task automatic load(input bit wr, input logic [5:0] a, input logic [3:0] bwn, input string tag);
    clk_en_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; adv_ld = 0;
    we_n = !wr; addr = a; lane_we_n = bwn;
    tick(tag);
  endtask

  task automatic adv(input logic [3:0] bwn, input string tag);
    clk_en_n = 0; adv_ld = 1; lane_we_n = bwn; addr = 6'($urandom); we_n = 1'($urandom);
    tick(tag);
  endtask

  task automatic desel(input int which, input string tag);
    clk_en_n = 0; adv_ld = 0; we_n = 1'($urandom); addr = 6'($urandom);
    ce1_n = (which == 1); ce2 = (which != 2); ce3_n = (which == 3);
    tick(tag);
  endtask

  task automatic stall(input string tag);
    clk_en_n = 1; adv_ld = 1'($urandom); we_n = 1'($urandom); addr = 6'($urandom);
    lane_we_n = 4'($urandom); ce1_n = 1'($urandom); ce2 = 1'($urandom); ce3_n = 1'($urandom);
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    model_reset();
    rst_n = 0; clk_en_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; we_n = 1; adv_ld = 0;
    order_ilv = 0; oe_n = 0; lane_we_n = 4'hF; addr = 0; wdata = 0;
    @(negedge clk);
    tick("R1");
    checks++;
    if (rdata !== '0 || bus_drive !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %h/%0b expected 0/0", rdata, bus_drive);
    end
    tick("R1");
    rst_n = 1;

    // R8 R6: fill the array with linear write bursts
    for (int i = 0; i < 16; i++) begin
      load(1, 6'(i * 4), 4'h0, "R8");
      for (int k = 0; k < 3; k++) adv(4'h0, "R6");
    end
    desel(1, "R3"); desel(2, "R3");

    // R4: single reads, one per load
    for (int i = 0; i < 8; i++) load(0, 6'(i * 7), 4'hF, "R4");
    desel(3, "R3"); desel(1, "R10");

    // R10: reads with output enable released
    oe_n = 1; load(0, 6'd5, 4'hF, "R10"); load(0, 6'd6, 4'hF, "R10");
    desel(1, "R10"); oe_n = 0; desel(1, "R10");

    // R8: partial lane write then read back
    load(1, 6'd9, 4'b0101, "R8"); desel(2, "R8"); desel(2, "R8");
    load(0, 6'd9, 4'hF, "R8"); desel(2, "R8"); desel(2, "R8");

    // R9: read right after write to same address
    load(1, 6'd20, 4'b0011, "R9"); load(0, 6'd20, 4'hF, "R9");
    load(1, 6'd21, 4'b1110, "R9"); load(0, 6'd21, 4'hF, "R9");
    desel(1, "R9"); desel(1, "R9");

    // R6: linear read burst from an odd start
    order_ilv = 0; load(0, 6'd13, 4'hF, "R6");
    for (int k = 0; k < 3; k++) adv(4'hF, "R6");
    desel(1, "R6"); desel(1, "R6");

    // R7: interleaved read and write bursts
    order_ilv = 1; load(0, 6'd14, 4'hF, "R7");
    for (int k = 0; k < 3; k++) adv(4'hF, "R7");
    load(1, 6'd23, 4'b1001, "R7");
    for (int k = 0; k < 3; k++) adv(4'(k), "R7");
    load(0, 6'd20, 4'hF, "R7");
    for (int k = 0; k < 3; k++) adv(4'hF, "R7");
    desel(2, "R7"); desel(2, "R7");

    // R2: stalls inside a burst
    order_ilv = 0; load(0, 6'd33, 4'hF, "R2"); adv(4'hF, "R2");
    for (int k = 0; k < 3; k++) stall("R2");
    adv(4'hF, "R2"); stall("R2"); adv(4'hF, "R2");
    load(1, 6'd40, 4'h0, "R2"); stall("R2"); stall("R2"); desel(1, "R2"); stall("R2");
    desel(1, "R2"); load(0, 6'd40, 4'hF, "R2"); desel(1, "R2"); desel(1, "R2");

    // R5 R3: advance while deselected does nothing; first window after deselect idle
    for (int w = 1; w <= 3; w++) begin
      desel(w, "R3"); adv(4'h0, "R5"); adv(4'h0, "R5");
      load(0, 6'(w * 11), 4'hF, "R10"); adv(4'hF, "R5"); desel(w, "R10"); desel(w, "R10");
    end

    // R11: reset in the middle of a write burst
    load(1, 6'd44, 4'h0, "R11"); adv(4'h0, "R11");
    rst_n = 0; tick("R11"); tick("R11"); rst_n = 1;
    desel(1, "R11"); desel(1, "R11");
    load(0, 6'd44, 4'hF, "R11"); load(0, 6'd45, 4'hF, "R11"); desel(1, "R11"); desel(1, "R11");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      oe_n = ($urandom_range(0, 4) == 0);
      order_ilv = (n >= 200);
      if (r < 3) load(1'($urandom), 6'($urandom), 4'($urandom), "R4");
      else if (r < 6) adv(4'($urandom), "R5");
      else if (r < 8) stall("R2");
      else desel($urandom_range(1, 3), "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule